// File: doc/BRIEF.md
# Stop-State Wakeup and Clock Recovery Controller

This block sits beside the clock generator of a small microcontroller and governs the way out of the low-power stop state. When software asks to stop and no wakeup cause is pending, the block gates the system clocks off. While stopped it watches six causes: the external reset line, a supply-below-threshold flag, an external interrupt line, a bank of keyboard lines, a debug break request and a periodic tick-counter wrap.

When a cause fires, a down-counter clocked by the oscillator holds the system clocks off so the oscillator can settle. A configuration input picks the settling time. It is 4096 oscillator cycles normally, or 32 cycles when the fast-wake bit is set. When the count runs out, the block turns the clocks back on. It presents the address of the vector pair that the program counter must load for the winning cause, and it marks the first clocked cycle with a one-cycle strobe.

The reset-class causes (external reset, low supply) always win. They restart a settling period that is already running and can take the block out of normal run as well. Interrupt-class causes can only end a stop. Interrupt-class causes that arrive during settling are dropped.

Top module: `stop_wake_ctrl`

## Requirements
- R1: In run state (clk_en high), a stop_req sampled with no wakeup cause pending is accepted, and clk_en is low from the next cycle on.
- R2: A stop_req sampled together with a pending interrupt-class cause (tick wrap, a detected line edge, or a break taken in debug mode) is refused, and clk_en stays high.
- R3: The settling time D is 32 cycles if fast_wake is 1 and 4096 cycles if it is 0, sampled on the edge that starts settling. If that edge is edge 0, clk_en stays low through the sample after edge D−1 and is high after edge D.
- R4: vec_valid is high for exactly the first cycle in which clk_en returns high after settling. vec_addr holds its value after that cycle.
- R5: ext_rst_n low or supply_low high selects vector 16'hFFFE. In any state, this starts settling or restarts a settling period already in progress.
- R6: A high-to-low change of ext_irq_n while stopped selects vector 16'hFFFA.
- R7: Keyboard line i wakes on a falling edge when key_rise[i] is 0 and on a rising edge when key_rise[i] is 1. It selects vector 16'hFFE0.
- R8: dbg_break wakes only while dbg_mode is 1, and selects vector 16'hFFFC. With dbg_mode at 0 it has no effect and the clocks stay off.
- R9: A tick_wrap pulse while stopped wakes the block and selects vector 16'hFFDC.
- R10: When causes fire in the same cycle, the order of precedence is reset-class, then break, then external interrupt, then keyboard, then tick wrap.
- R11: Interrupt-class causes during run or during settling change neither clk_en, vec_addr nor the time at which settling ends.
- R12: After rst_n is released, clk_en is 1, vec_valid is 0 and vec_addr is 16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| fast_wake | input | 1 | 1 selects the short settling time |
| stop_req | input | 1 | Request to enter the stop state |
| ext_rst_n | input | 1 | External reset cause, active low |
| supply_low | input | 1 | Supply-below-threshold cause, active high |
| ext_irq_n | input | 1 | External interrupt line, falling edge wakes |
| key_in | input | KBD_PINS | Keyboard interrupt lines |
| key_rise | input | KBD_PINS | Per-line edge polarity, 1 = rising |
| dbg_mode | input | 1 | Debug mode; gates dbg_break |
| dbg_break | input | 1 | Debug break request |
| tick_wrap | input | 1 | Tick-counter wrap pulse |
| clk_en | output | 1 | System clock enable |
| vec_addr | output | 16 | First location of the selected vector pair |
| vec_valid | output | 1 | One-cycle strobe when clocks return |

## Verification
The wakeup path is tried with each cause alone: both reset-class inputs, a falling-edge keyboard line, a rising-edge keyboard line, break, external interrupt and tick wrap. Each of these checks whether the vector is mapped to the right cause and whether the keyboard polarity is decoded for each line. The same path is driven with causes combined in one cycle, which checks the order of precedence. One run uses the long setting and the rest use the short one, so the exact turn-on cycle checks both count lengths. Directed runs inject a reset during settling, which must restart the count. They also inject interrupts during settling and during run, which must be dropped, apply break without debug mode, which must be ignored, and issue a stop request while a cause is pending, which must be refused.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

    localparam int VEC_W   = 16;
    localparam int NUM_SRC = 5;

    // Cause indices: a lower index has higher precedence
    localparam int SRC_RST = 0;
    localparam int SRC_BRK = 1;
    localparam int SRC_IRQ = 2;
    localparam int SRC_KEY = 3;
    localparam int SRC_TCK = 4;

    localparam logic [VEC_W-1:0] VEC_RESET = 16'hFFFE;
    localparam logic [VEC_W-1:0] VEC_BREAK = 16'hFFFC;
    localparam logic [VEC_W-1:0] VEC_IRQ   = 16'hFFFA;
    localparam logic [VEC_W-1:0] VEC_KEY   = 16'hFFE0;
    localparam logic [VEC_W-1:0] VEC_TICK  = 16'hFFDC;

    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_STOP    = 2'd1,
        PM_SETTLE  = 2'd2
    } pm_state_e;

    function automatic logic [VEC_W-1:0] src_vector(input int idx);
        case (idx)
            SRC_RST: src_vector = VEC_RESET;
            SRC_BRK: src_vector = VEC_BREAK;
            SRC_IRQ: src_vector = VEC_IRQ;
            SRC_KEY: src_vector = VEC_KEY;
            default: src_vector = VEC_TICK;
        endcase
    endfunction

endpackage

// File: rtl/wake_edge_detect.sv
module wake_edge_detect #(
    parameter int KBD_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_irq_n,
    input  logic [KBD_PINS-1:0] key_in,
    input  logic [KBD_PINS-1:0] key_rise,
    output logic                irq_fall,
    output logic                key_hit
);

    typedef struct packed {
        logic                primed;
        logic                irq_prev;
        logic [KBD_PINS-1:0] key_prev;
    } edge_regs_t;

    edge_regs_t regs_d, regs_q;
    logic [KBD_PINS-1:0] pin_hit;

    always_comb begin
        regs_d          = regs_q;
        regs_d.primed   = 1'b1;
        regs_d.irq_prev = ext_irq_n;
        regs_d.key_prev = key_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{primed: 1'b0, irq_prev: 1'b1, key_prev: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    // Per-line edge selection by polarity
    for (genvar i = 0; i < KBD_PINS; i++) begin : g_key
        logic rise_seen, fall_seen;
        assign rise_seen  = !regs_q.key_prev[i] &&  key_in[i];
        assign fall_seen  =  regs_q.key_prev[i] && !key_in[i];
        assign pin_hit[i] = key_rise[i] ? rise_seen : fall_seen;
    end

    assign irq_fall = regs_q.primed && regs_q.irq_prev && !ext_irq_n;
    assign key_hit  = regs_q.primed && (|pin_hit);

    AST_IRQ_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fall |=> !irq_fall);  // R6

endmodule

// File: rtl/wake_prio_sel.sv
module wake_prio_sel
    import stop_wake_pkg::*;
(
    input  logic             rst_src,
    input  logic             brk_src,
    input  logic             irq_src,
    input  logic             key_src,
    input  logic             tck_src,
    output logic [NUM_SRC-1:0] grant,
    output logic             any_src,
    output logic [VEC_W-1:0] sel_vec
);

    logic [NUM_SRC-1:0] req;

    always_comb begin
        logic found;
        req          = '0;
        req[SRC_RST] = rst_src;
        req[SRC_BRK] = brk_src;
        req[SRC_IRQ] = irq_src;
        req[SRC_KEY] = key_src;
        req[SRC_TCK] = tck_src;
        grant   = '0;
        sel_vec = VEC_RESET;
        found   = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                sel_vec  = src_vector(i);
                found    = 1'b1;
            end
        end
        any_src = found;
    end

    always_comb begin
        if (!$isunknown(req)) begin
            AST_GRANT_ONEHOT: assert ($onehot0(grant));  // R10
        end
    end

endmodule

// File: rtl/wake_recovery_timer.sv
module wake_recovery_timer #(
    parameter int LONG_DELAY  = 4096,
    parameter int SHORT_DELAY = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic short_sel,
    input  logic count_en,
    output logic done
);

    localparam int CNT_W = $clog2(LONG_DELAY);
    localparam logic [CNT_W-1:0] LONG_RELOAD  = CNT_W'(LONG_DELAY - 1);
    localparam logic [CNT_W-1:0] SHORT_RELOAD = CNT_W'(SHORT_DELAY - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (load) begin
            regs_d.cnt = short_sel ? SHORT_RELOAD : LONG_RELOAD;
        end else if (count_en && regs_q.cnt != '0) begin
            regs_d.cnt = regs_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign done = (regs_q.cnt == '0);

    AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !load && regs_q.cnt != '0) |=> regs_q.cnt == $past(regs_q.cnt) - 1'b1);  // R3
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> regs_q.cnt == ($past(short_sel) ? SHORT_RELOAD : LONG_RELOAD));  // R3

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import stop_wake_pkg::*;
#(
    parameter int KBD_PINS    = 4,
    parameter int LONG_DELAY  = 4096,
    parameter int SHORT_DELAY = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fast_wake,
    input  logic                stop_req,
    input  logic                ext_rst_n,
    input  logic                supply_low,
    input  logic                ext_irq_n,
    input  logic [KBD_PINS-1:0] key_in,
    input  logic [KBD_PINS-1:0] key_rise,
    input  logic                dbg_mode,
    input  logic                dbg_break,
    input  logic                tick_wrap,
    output logic                clk_en,
    output logic [VEC_W-1:0]    vec_addr,
    output logic                vec_valid
);

    typedef struct packed {
        pm_state_e        state;
        logic [VEC_W-1:0] vec;
        logic             valid;
    } ctl_regs_t;

    ctl_regs_t regs_d, regs_q;

    logic               irq_fall, key_hit;
    logic               rst_src, brk_src;
    logic [NUM_SRC-1:0] grant;
    logic               any_src;
    logic [VEC_W-1:0]   sel_vec;
    logic               tmr_load, tmr_en, tmr_done;

    assign rst_src = !ext_rst_n || supply_low;
    assign brk_src = dbg_mode && dbg_break;

    wake_edge_detect #(.KBD_PINS(KBD_PINS)) edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_irq_n (ext_irq_n),
        .key_in    (key_in),
        .key_rise  (key_rise),
        .irq_fall  (irq_fall),
        .key_hit   (key_hit)
    );

    wake_prio_sel prio_i (
        .rst_src (rst_src),
        .brk_src (brk_src),
        .irq_src (irq_fall),
        .key_src (key_hit),
        .tck_src (tick_wrap),
        .grant   (grant),
        .any_src (any_src),
        .sel_vec (sel_vec)
    );

    wake_recovery_timer #(
        .LONG_DELAY  (LONG_DELAY),
        .SHORT_DELAY (SHORT_DELAY)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tmr_load),
        .short_sel (fast_wake),
        .count_en  (tmr_en),
        .done      (tmr_done)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.valid = 1'b0;
        tmr_load     = 1'b0;
        tmr_en       = 1'b0;
        unique case (regs_q.state)
            PM_RUN: begin
                if (rst_src) begin
                    regs_d.state = PM_SETTLE;
                    regs_d.vec   = VEC_RESET;
                    tmr_load     = 1'b1;
                end else if (stop_req && !any_src) begin
                    regs_d.state = PM_STOP;
                end
            end
            PM_STOP: begin
                if (any_src) begin
                    regs_d.state = PM_SETTLE;
                    regs_d.vec   = sel_vec;
                    tmr_load     = 1'b1;
                end
            end
            PM_SETTLE: begin
                if (rst_src) begin
                    regs_d.vec = VEC_RESET;
                    tmr_load   = 1'b1;
                end else if (tmr_done) begin
                    regs_d.state = PM_RUN;
                    regs_d.valid = 1'b1;
                end else begin
                    tmr_en = 1'b1;
                end
            end
            default: begin
                regs_d.state = PM_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: PM_RUN, vec: VEC_RESET, valid: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign clk_en    = (regs_q.state == PM_RUN);
    assign vec_addr  = regs_q.vec;
    assign vec_valid = regs_q.valid;

    AST_STOP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && stop_req && !any_src) |=> !clk_en);  // R1
    AST_STOP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !rst_src && any_src) |=> clk_en);  // R2
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);  // R4
    AST_VALID_WITH_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> clk_en);  // R4
    AST_RESET_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        rst_src |=> (!clk_en && vec_addr == VEC_RESET));  // R5
    AST_RUN_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !rst_src) |=> $stable(vec_addr));  // R11

endmodule

// File: tb/stop_wake_ctrl_tb.sv
module stop_wake_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int KP         = 4;
    localparam logic [KP-1:0] KEY_IDLE = 4'b1011;
    localparam logic [KP-1:0] KEY_POL  = 4'b0100;
    localparam int N_VEC = 8;

    // source codes: 0 ext reset, 1 supply low, 2 irq, 3 key line0 fall,
    // 4 key line2 rise, 5 break in debug mode, 6 tick wrap
    localparam int          T_SRC   [N_VEC] = '{0, 1, 2, 3, 4, 5, 6, 2};
    localparam logic        T_FAST  [N_VEC] = '{1, 1, 1, 1, 1, 1, 1, 0};
    localparam logic [15:0] T_VEC   [N_VEC] = '{16'hFFFE, 16'hFFFE, 16'hFFFA, 16'hFFE0,
                                                16'hFFE0, 16'hFFFC, 16'hFFDC, 16'hFFFA};

    logic clk = 1'b0;
    logic rst_n;
    logic fast_wake, stop_req, ext_rst_n, supply_low, ext_irq_n;
    logic [KP-1:0] key_in, key_rise;
    logic dbg_mode, dbg_break, tick_wrap;
    logic clk_en, vec_valid;
    logic [15:0] vec_addr;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stop_wake_ctrl #(.KBD_PINS(KP), .LONG_DELAY(4096), .SHORT_DELAY(32)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast_wake  (fast_wake),
        .stop_req   (stop_req),
        .ext_rst_n  (ext_rst_n),
        .supply_low (supply_low),
        .ext_irq_n  (ext_irq_n),
        .key_in     (key_in),
        .key_rise   (key_rise),
        .dbg_mode   (dbg_mode),
        .dbg_break  (dbg_break),
        .tick_wrap  (tick_wrap),
        .clk_en     (clk_en),
        .vec_addr   (vec_addr),
        .vec_valid  (vec_valid)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic release_pulses();
        ext_rst_n  = 1'b1;
        supply_low = 1'b0;
        dbg_break  = 1'b0;
        dbg_mode   = 1'b0;
        tick_wrap  = 1'b0;
    endtask

    task automatic restore_idle();
        ext_irq_n = 1'b1;
        key_in    = KEY_IDLE;
    endtask

    task automatic enter_stop();
        stop_req = 1'b1;
        step();
        stop_req = 1'b0;
        chk("R1 clocks gated after stop accepted", {31'd0, clk_en}, 32'd0);
    endtask

    task automatic apply_src(input int src);
        case (src)
            0: ext_rst_n = 1'b0;
            1: supply_low = 1'b1;
            2: ext_irq_n = 1'b0;
            3: key_in[0] = 1'b0;
            4: key_in[2] = 1'b1;
            5: begin dbg_mode = 1'b1; dbg_break = 1'b1; end
            default: tick_wrap = 1'b1;
        endcase
    endtask

    // Causes are set up at the current negedge; the next edge starts settling.
    task automatic finish_wake(input logic [15:0] exp_vec, input int dly, input string tag);
        step();
        release_pulses();
        chk({tag, " R3 clocks off at start of settling"}, {31'd0, clk_en}, 32'd0);
        repeat (dly - 1) step();
        chk({tag, " R3 clocks still off at last settling cycle"}, {31'd0, clk_en}, 32'd0);
        step();
        chk({tag, " R3 clocks back on"}, {31'd0, clk_en}, 32'd1);
        chk({tag, " R4 strobe on first clocked cycle"}, {31'd0, vec_valid}, 32'd1);
        chk({tag, " vector"}, {16'd0, vec_addr}, {16'd0, exp_vec});
        step();
        chk({tag, " R4 strobe lasts one cycle"}, {31'd0, vec_valid}, 32'd0);
        chk({tag, " R4 vector held"}, {16'd0, vec_addr}, {16'd0, exp_vec});
        restore_idle();
        step();
    endtask

    function automatic string src_tag(input int src);
        case (src)
            0: src_tag = "R5 ext reset";
            1: src_tag = "R5 supply low";
            2: src_tag = "R6 irq edge";
            3: src_tag = "R7 key fall";
            4: src_tag = "R7 key rise";
            5: src_tag = "R8 break";
            default: src_tag = "R9 tick";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog R3: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        fast_wake = 1'b1;
        stop_req  = 1'b0;
        key_rise  = KEY_POL;
        release_pulses();
        restore_idle();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R12 clk_en after reset", {31'd0, clk_en}, 32'd1);
        chk("R12 vec_valid after reset", {31'd0, vec_valid}, 32'd0);
        chk("R12 vec_addr after reset", {16'd0, vec_addr}, 32'h0000FFFE);
        step();

        // Table walk: one cause per entry
        for (int k = 0; k < N_VEC; k++) begin
            fast_wake = T_FAST[k];
            enter_stop();
            step();
            apply_src(T_SRC[k]);
            finish_wake(T_VEC[k], T_FAST[k] ? 32 : 4096, src_tag(T_SRC[k]));
        end
        fast_wake = 1'b1;

        // R2 / R11: stop refused with tick pending; tick ignored in run
        stop_req  = 1'b1;
        tick_wrap = 1'b1;
        step();
        stop_req  = 1'b0;
        tick_wrap = 1'b0;
        chk("R2 stop refused with pending cause", {31'd0, clk_en}, 32'd1);
        chk("R11 run ignores tick (vector)", {16'd0, vec_addr}, 32'h0000FFFA);
        step();
        chk("R11 run ignores tick (strobe)", {31'd0, vec_valid}, 32'd0);

        // R10: precedence checks
        enter_stop();
        ext_irq_n = 1'b0; tick_wrap = 1'b1; dbg_mode = 1'b1; dbg_break = 1'b1;
        finish_wake(16'hFFFC, 32, "R10 break over irq and tick");
        enter_stop();
        ext_irq_n = 1'b0; key_in[0] = 1'b0;
        finish_wake(16'hFFFA, 32, "R10 irq over key");
        enter_stop();
        supply_low = 1'b1; dbg_mode = 1'b1; dbg_break = 1'b1;
        finish_wake(16'hFFFE, 32, "R10 reset over break");
        enter_stop();
        key_in[2] = 1'b1; tick_wrap = 1'b1;
        finish_wake(16'hFFE0, 32, "R10 key over tick");

        // R8: break without debug mode has no effect
        enter_stop();
        dbg_break = 1'b1;
        repeat (5) step();
        chk("R8 break ignored outside debug mode", {31'd0, clk_en}, 32'd0);
        dbg_break = 1'b0;
        tick_wrap = 1'b1;
        finish_wake(16'hFFDC, 32, "R9 tick after ignored break");

        // R11: interrupts during settling dropped
        enter_stop();
        tick_wrap = 1'b1;
        step();
        tick_wrap = 1'b0;
        repeat (5) step();
        ext_irq_n = 1'b0;
        key_in[0] = 1'b0;
        step();
        repeat (25) step();
        chk("R11 settling length unchanged (off)", {31'd0, clk_en}, 32'd0);
        step();
        chk("R11 settling length unchanged (on)", {31'd0, clk_en}, 32'd1);
        chk("R11 vector unchanged by late irq", {16'd0, vec_addr}, 32'h0000FFDC);
        restore_idle();
        repeat (2) step();

        // R5: reset during settling restarts the count
        enter_stop();
        tick_wrap = 1'b1;
        step();
        tick_wrap = 1'b0;
        repeat (9) step();
        ext_rst_n = 1'b0;
        step();
        ext_rst_n = 1'b1;
        repeat (31) step();
        chk("R5 restart keeps clocks off", {31'd0, clk_en}, 32'd0);
        step();
        chk("R5 restart clocks on", {31'd0, clk_en}, 32'd1);
        chk("R5 restart vector", {16'd0, vec_addr}, 32'h0000FFFE);
        step();

        // R5: reset-class cause in run state
        supply_low = 1'b1;
        finish_wake(16'hFFFE, 32, "R5 reset from run");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule